// File: doc/BRIEF.md
# Packed Two-Slot Issue Queue

This block is the wakeup and select core of an out-of-order issue queue in which each physical entry is split into a left half and a right half. Each half owns one source-tag comparator. An instruction that is waiting on at most one source fits in a single half, so two such instructions share one entry. An instruction waiting on both sources spans the whole entry: one source tag sits in each half's comparator, and the entry is said to be in full mode.

Dispatch presents one instruction per cycle with its opcode, destination tag, two source tags and a ready flag for each source. The queue answers in the same cycle whether it has room. Completing instructions broadcast their destination tags on one or more wakeup buses, and matching comparators mark their sources valid. Every half drives a request line. A lowest-index arbiter picks one request per cycle, and the issue port returns the chosen instruction's opcode, destination and both source tags in their original order. The granted half, or the whole entry in full mode, is released at the clock edge.

Each entry is a small state machine with five states. EMPTY holds nothing. LEFT and RIGHT each hold one packed instruction in the named half. BOTH holds two packed instructions. FULL holds one instruction across the whole entry. The transitions are:
- EMPTY→FULL on a full dispatch.
- EMPTY→LEFT on a half dispatch.
- LEFT→BOTH and RIGHT→BOTH when the free half is filled.
- LEFT→EMPTY and RIGHT→EMPTY when the occupied half is granted.
- LEFT→RIGHT and RIGHT→LEFT when a grant and a fill of the other half happen in the same cycle.
- BOTH→RIGHT on a left grant, and BOTH→LEFT on a right grant.
- FULL→EMPTY on a grant.

Top module: `pkiq_top`

## Requirements
- R1: After reset every entry is EMPTY: `req_lo` and `req_hi` are all zero, `iss_vld` is 0, and a dispatch is accepted (`dsp_acc` = `dsp_vld`).
- R2: An instruction with both ready flags low is a full instruction and occupies a whole entry. Any other instruction is a half instruction. A full entry raises no request line while either of its sources is still waiting.
- R3: A half instruction goes into the free half of the lowest-index entry that has exactly one occupied half. If there is no such entry, it goes into the left half of the lowest-index EMPTY entry. If neither exists, `dsp_acc` is 0 and the instruction is dropped.
- R4: A full instruction goes into the lowest-index EMPTY entry. If there is none, `dsp_acc` is 0.
- R5: A half instruction with both sources ready raises its half's request line in the cycle after the dispatch edge.
- R6: A wakeup bus whose valid bit is set and whose tag equals a stored comparator tag sets that source valid at the edge. A packed half then requests from the next cycle until it is granted. Buses with the valid bit low have no effect.
- R7: A full entry drives only its right request line, which is high exactly when both of its sources are valid. Its left request line stays low.
- R8: A wakeup broadcast in the same cycle as the dispatch of an instruction whose waiting source has that tag counts as a wakeup for that instruction.
- R9: At most one request is granted per cycle, namely the lowest slot index, where slot = 2*entry + (0 for the left half, 1 for the right half). A full entry issues as slot 2*entry+1. `iss_vld` and `iss_slot` show the grant combinationally.
- R10: The issue port returns the granted instruction's opcode, destination tag and its two source tags in dispatch order, whichever source sat in a comparator.
- R11: A granted half, or a granted full entry, is released at the grant edge. Its request line is low in the next cycle, and the freed space can be allocated from that cycle on.
- R12: An entry whose halves have both been released returns to EMPTY and can then accept a full instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsp_vld | input | 1 | Dispatch request |
| dsp_op | input | OP_W | Opcode of the dispatched instruction |
| dsp_dst | input | TAG_W | Destination tag |
| dsp_s0 | input | TAG_W | First source tag |
| dsp_s0_rdy | input | 1 | First source already available |
| dsp_s1 | input | TAG_W | Second source tag |
| dsp_s1_rdy | input | 1 | Second source already available |
| dsp_acc | output | 1 | Dispatch accepted this cycle |
| wk_vld | input | NUM_BUS | Per-bus broadcast valid |
| wk_tag | input | NUM_BUS*TAG_W | Broadcast tags, bus b at bits b*TAG_W upward |
| req_lo | output | NUM_ENT | Left-half request per entry |
| req_hi | output | NUM_ENT | Right-half request per entry |
| iss_vld | output | 1 | An instruction is issued this cycle |
| iss_slot | output | $clog2(2*NUM_ENT) | Granted slot index |
| iss_op | output | OP_W | Issued opcode |
| iss_dst | output | TAG_W | Issued destination tag |
| iss_s0 | output | TAG_W | Issued first source tag |
| iss_s1 | output | TAG_W | Issued second source tag |

## Verification
`dsp_acc`, `iss_vld`, `iss_slot` and the issue payload are combinational and are due in the same cycle as the state and inputs they depend on. Request lines, wakeups, releases and newly allocated space all show up one edge after their cause. The bench drives inputs on the falling edge and samples outputs 1 ns later, against a model state that it advances only at the rising edge. A single-edge delay therefore shows up as exactly one step of the model. Hand checks in the directed sequence are placed at the step that follows their cause.

// File: rtl/pkiq_pkg.sv
package pkiq_pkg;

    // Occupancy of one physical entry
    typedef enum logic [2:0] {
        E_EMPTY = 3'd0,   // nothing stored
        E_LEFT  = 3'd1,   // one packed instruction in the left half
        E_RIGHT = 3'd2,   // one packed instruction in the right half
        E_BOTH  = 3'd3,   // two packed instructions
        E_FULL  = 3'd4    // one instruction across the whole entry
    } ent_st_e;

endpackage

// File: rtl/pkiq_alloc.sv
module pkiq_alloc
    import pkiq_pkg::*;
#(
    parameter int NUM_ENT = 8,
    localparam int ENT_W = $clog2(NUM_ENT)
) (
    input  ent_st_e            st [NUM_ENT],
    output logic               half_ok,
    output logic [ENT_W-1:0]   half_ent,
    output logic               half_rt,
    output logic               full_ok,
    output logic [ENT_W-1:0]   full_ent
);

    logic             part_fnd;
    logic [ENT_W-1:0] part_idx;
    logic             part_rt;
    logic             empty_fnd;
    logic [ENT_W-1:0] empty_idx;

    // Parallel scan: first half-occupied entry and first empty entry
    always_comb begin
        part_fnd  = 1'b0;
        part_idx  = '0;
        part_rt   = 1'b0;
        empty_fnd = 1'b0;
        empty_idx = '0;
        for (int e = 0; e < NUM_ENT; e++) begin
            if (!part_fnd && (st[e] == E_LEFT || st[e] == E_RIGHT)) begin
                part_fnd = 1'b1;
                part_idx = ENT_W'(e);
                part_rt  = (st[e] == E_LEFT);
            end
            if (!empty_fnd && st[e] == E_EMPTY) begin
                empty_fnd = 1'b1;
                empty_idx = ENT_W'(e);
            end
        end
    end

    // Packing first: fill a lone half before opening a new entry
    always_comb begin
        half_ok  = part_fnd || empty_fnd;
        half_ent = part_fnd ? part_idx : empty_idx;
        half_rt  = part_fnd ? part_rt : 1'b0;
        full_ok  = empty_fnd;
        full_ent = empty_idx;
    end

endmodule

// File: rtl/pkiq_select.sv
module pkiq_select #(
    parameter int SLOTS = 16,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0]  req,
    output logic [SLOTS-1:0]  gnt,
    output logic              gnt_vld,
    output logic [SLOT_W-1:0] gnt_idx
);

    always_comb begin
        gnt     = '0;
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (!gnt_vld && req[s]) begin
                gnt_vld = 1'b1;
                gnt_idx = SLOT_W'(s);
                gnt[s]  = 1'b1;
            end
        end
    end

    always_comb begin
        AST_ONE_GRANT: assert ($onehot0(gnt));              // R9
        AST_GRANT_HAS_REQ: assert ((gnt & ~req) == '0);     // R9
    end

endmodule

// File: rtl/pkiq_entry.sv
module pkiq_entry
    import pkiq_pkg::*;
#(
    parameter int TAG_W   = 6,
    parameter int OP_W    = 4,
    parameter int NUM_BUS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_BUS-1:0]        bc_vld,
    input  logic [NUM_BUS*TAG_W-1:0]  bc_tag,
    input  logic                      wr_l,
    input  logic                      wr_r,
    input  logic                      wr_full,
    input  logic [OP_W-1:0]           wr_op,
    input  logic [TAG_W-1:0]          wr_dst,
    input  logic [TAG_W-1:0]          wr_ctag,
    input  logic [TAG_W-1:0]          wr_xtag,
    input  logic                      wr_swp,
    input  logic                      wr_crdy,
    input  logic [TAG_W-1:0]          wr_s0,
    input  logic [TAG_W-1:0]          wr_s1,
    input  logic                      gnt_l,
    input  logic                      gnt_r,
    output ent_st_e                   st_o,
    output logic                      req_l,
    output logic                      req_r,
    output logic [OP_W-1:0]           op_l,
    output logic [TAG_W-1:0]          dst_l,
    output logic [TAG_W-1:0]          s0_l,
    output logic [TAG_W-1:0]          s1_l,
    output logic [OP_W-1:0]           op_r,
    output logic [TAG_W-1:0]          dst_r,
    output logic [TAG_W-1:0]          s0_r,
    output logic [TAG_W-1:0]          s1_r
);

    ent_st_e st, st_nx;

    // Comparator tags (CAM) and payload (RAM) per half
    logic [TAG_W-1:0] ctag_l_q, ctag_r_q;
    logic [TAG_W-1:0] xtag_l_q, xtag_r_q;
    logic             swp_l_q, swp_r_q;
    logic [OP_W-1:0]  op_l_q, op_r_q;
    logic [TAG_W-1:0] dst_l_q, dst_r_q;
    logic             svl_q, svr_q, rdy_q;
    logic             svl_nx, svr_nx, rdy_nx;
    logic             hit_l, hit_r, hit_wc, hit_w0, hit_w1;

    function automatic logic tag_hit(input logic [TAG_W-1:0] t,
                                     input logic [NUM_BUS-1:0] v,
                                     input logic [NUM_BUS*TAG_W-1:0] tg);
        logic h;
        h = 1'b0;
        for (int b = 0; b < NUM_BUS; b++)
            h = h | (v[b] && (tg[b*TAG_W +: TAG_W] == t));
        return h;
    endfunction

    always_comb begin
        hit_l  = tag_hit(ctag_l_q, bc_vld, bc_tag);
        hit_r  = tag_hit(ctag_r_q, bc_vld, bc_tag);
        hit_wc = tag_hit(wr_ctag,  bc_vld, bc_tag);
        hit_w0 = tag_hit(wr_s0,    bc_vld, bc_tag);
        hit_w1 = tag_hit(wr_s1,    bc_vld, bc_tag);
    end

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            E_EMPTY: begin
                if (wr_full)   st_nx = E_FULL;
                else if (wr_l) st_nx = E_LEFT;
                else if (wr_r) st_nx = E_RIGHT;
            end
            E_LEFT: begin
                if (gnt_l && wr_r)  st_nx = E_RIGHT;
                else if (gnt_l)     st_nx = E_EMPTY;
                else if (wr_r)      st_nx = E_BOTH;
            end
            E_RIGHT: begin
                if (gnt_r && wr_l)  st_nx = E_LEFT;
                else if (gnt_r)     st_nx = E_EMPTY;
                else if (wr_l)      st_nx = E_BOTH;
            end
            E_BOTH: begin
                if (gnt_l)          st_nx = E_RIGHT;
                else if (gnt_r)     st_nx = E_LEFT;
            end
            E_FULL: begin
                if (gnt_r)          st_nx = E_EMPTY;
            end
        endcase
    end

    // Valid bits: load on write (with same-cycle snoop), else accumulate matches
    always_comb begin
        if (wr_full)   svl_nx = hit_w1;
        else if (wr_l) svl_nx = wr_crdy | hit_wc;
        else           svl_nx = svl_q | hit_l;
        if (wr_full)   svr_nx = hit_w0;
        else if (wr_r) svr_nx = wr_crdy | hit_wc;
        else           svr_nx = svr_q | hit_r;
        rdy_nx = (st_nx == E_FULL) && svl_nx && svr_nx;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= E_EMPTY;
            svl_q <= 1'b0;
            svr_q <= 1'b0;
            rdy_q <= 1'b0;
        end else begin
            st    <= st_nx;
            svl_q <= svl_nx;
            svr_q <= svr_nx;
            rdy_q <= rdy_nx;
        end
    end

    // Tag and payload storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctag_l_q <= '0; ctag_r_q <= '0;
            xtag_l_q <= '0; xtag_r_q <= '0;
            swp_l_q  <= 1'b0; swp_r_q <= 1'b0;
            op_l_q   <= '0; op_r_q   <= '0;
            dst_l_q  <= '0; dst_r_q  <= '0;
        end else begin
            if (wr_l) begin
                ctag_l_q <= wr_ctag;
                xtag_l_q <= wr_xtag;
                swp_l_q  <= wr_swp;
                op_l_q   <= wr_op;
                dst_l_q  <= wr_dst;
            end
            if (wr_r) begin
                ctag_r_q <= wr_ctag;
                xtag_r_q <= wr_xtag;
                swp_r_q  <= wr_swp;
                op_r_q   <= wr_op;
                dst_r_q  <= wr_dst;
            end
            if (wr_full) begin
                // first source in the right CAM, second in the left CAM,
                // second also kept in the left payload for register read
                ctag_r_q <= wr_s0;
                ctag_l_q <= wr_s1;
                xtag_l_q <= wr_s1;
                swp_r_q  <= 1'b0;
                op_r_q   <= wr_op;
                dst_r_q  <= wr_dst;
            end
        end
    end

    // Outputs: requests and per-half issue view
    always_comb begin
        st_o  = st;
        req_l = (st == E_LEFT || st == E_BOTH) && svl_q;
        req_r = ((st == E_RIGHT || st == E_BOTH) && svr_q) || ((st == E_FULL) && rdy_q);
        op_l  = op_l_q;
        dst_l = dst_l_q;
        s0_l  = swp_l_q ? xtag_l_q : ctag_l_q;
        s1_l  = swp_l_q ? ctag_l_q : xtag_l_q;
        op_r  = op_r_q;
        dst_r = dst_r_q;
        if (st == E_FULL) begin
            s0_r = ctag_r_q;
            s1_r = xtag_l_q;
        end else begin
            s0_r = swp_r_q ? xtag_r_q : ctag_r_q;
            s1_r = swp_r_q ? ctag_r_q : xtag_r_q;
        end
    end

    AST_REQ_HOLD_L: assert property (@(posedge clk) disable iff (!rst_n)
        (req_l && !gnt_l) |=> req_l);                                         // R6
    AST_REQ_HOLD_R: assert property (@(posedge clk) disable iff (!rst_n)
        (req_r && !gnt_r) |=> req_r);                                         // R6
    AST_WAKE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == E_LEFT || st == E_BOTH) && hit_l && !gnt_l) |=> req_l);       // R6
    AST_GRANT_FREES_L: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_l |=> !req_l);                                                    // R11
    AST_FULL_READY_AND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == E_FULL) |-> (rdy_q == (svl_q && svr_q)));                      // R7

endmodule

// File: rtl/pkiq_top.sv
module pkiq_top
    import pkiq_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int TAG_W   = 6,
    parameter int OP_W    = 4,
    parameter int NUM_BUS = 2,
    localparam int SLOTS  = 2 * NUM_ENT,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int ENT_W  = $clog2(NUM_ENT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dsp_vld,
    input  logic [OP_W-1:0]           dsp_op,
    input  logic [TAG_W-1:0]          dsp_dst,
    input  logic [TAG_W-1:0]          dsp_s0,
    input  logic                      dsp_s0_rdy,
    input  logic [TAG_W-1:0]          dsp_s1,
    input  logic                      dsp_s1_rdy,
    output logic                      dsp_acc,
    input  logic [NUM_BUS-1:0]        wk_vld,
    input  logic [NUM_BUS*TAG_W-1:0]  wk_tag,
    output logic [NUM_ENT-1:0]        req_lo,
    output logic [NUM_ENT-1:0]        req_hi,
    output logic                      iss_vld,
    output logic [SLOT_W-1:0]         iss_slot,
    output logic [OP_W-1:0]           iss_op,
    output logic [TAG_W-1:0]          iss_dst,
    output logic [TAG_W-1:0]          iss_s0,
    output logic [TAG_W-1:0]          iss_s1
);

    ent_st_e          st_a [NUM_ENT];
    logic [OP_W-1:0]  op_l_a [NUM_ENT], op_r_a [NUM_ENT];
    logic [TAG_W-1:0] dst_l_a [NUM_ENT], dst_r_a [NUM_ENT];
    logic [TAG_W-1:0] s0_l_a [NUM_ENT], s0_r_a [NUM_ENT];
    logic [TAG_W-1:0] s1_l_a [NUM_ENT], s1_r_a [NUM_ENT];

    logic             half_ok, half_rt, full_ok;
    logic [ENT_W-1:0] half_ent, full_ent;
    logic             is_full;
    logic [TAG_W-1:0] w_ctag, w_xtag;
    logic             w_swp, w_crdy;
    logic [SLOTS-1:0] req_all, gnt;
    logic             gnt_vld;
    logic [SLOT_W-1:0] gnt_idx;
    logic [ENT_W-1:0] g_ent;
    logic             g_rt;

    // Classify and pack the dispatched instruction
    always_comb begin
        is_full = !dsp_s0_rdy && !dsp_s1_rdy;
        if (!dsp_s0_rdy) begin
            w_ctag = dsp_s0; w_xtag = dsp_s1; w_swp = 1'b0; w_crdy = 1'b0;
        end else if (!dsp_s1_rdy) begin
            w_ctag = dsp_s1; w_xtag = dsp_s0; w_swp = 1'b1; w_crdy = 1'b0;
        end else begin
            w_ctag = dsp_s0; w_xtag = dsp_s1; w_swp = 1'b0; w_crdy = 1'b1;
        end
        dsp_acc = dsp_vld && (is_full ? full_ok : half_ok);
    end

    pkiq_alloc #(.NUM_ENT(NUM_ENT)) u_alloc (
        .st       (st_a),
        .half_ok  (half_ok),
        .half_ent (half_ent),
        .half_rt  (half_rt),
        .full_ok  (full_ok),
        .full_ent (full_ent)
    );

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent_arr
        logic wl, wr, wf;
        assign wf = dsp_acc && is_full && (full_ent == ENT_W'(e));
        assign wl = dsp_acc && !is_full && !half_rt && (half_ent == ENT_W'(e));
        assign wr = dsp_acc && !is_full &&  half_rt && (half_ent == ENT_W'(e));

        pkiq_entry #(.TAG_W(TAG_W), .OP_W(OP_W), .NUM_BUS(NUM_BUS)) u_ent (
            .clk     (clk),
            .rst_n   (rst_n),
            .bc_vld  (wk_vld),
            .bc_tag  (wk_tag),
            .wr_l    (wl),
            .wr_r    (wr),
            .wr_full (wf),
            .wr_op   (dsp_op),
            .wr_dst  (dsp_dst),
            .wr_ctag (w_ctag),
            .wr_xtag (w_xtag),
            .wr_swp  (w_swp),
            .wr_crdy (w_crdy),
            .wr_s0   (dsp_s0),
            .wr_s1   (dsp_s1),
            .gnt_l   (gnt[2*e]),
            .gnt_r   (gnt[2*e+1]),
            .st_o    (st_a[e]),
            .req_l   (req_lo[e]),
            .req_r   (req_hi[e]),
            .op_l    (op_l_a[e]),
            .dst_l   (dst_l_a[e]),
            .s0_l    (s0_l_a[e]),
            .s1_l    (s1_l_a[e]),
            .op_r    (op_r_a[e]),
            .dst_r   (dst_r_a[e]),
            .s0_r    (s0_r_a[e]),
            .s1_r    (s1_r_a[e])
        );

        assign req_all[2*e]   = req_lo[e];
        assign req_all[2*e+1] = req_hi[e];
    end

    pkiq_select #(.SLOTS(SLOTS)) u_sel (
        .req     (req_all),
        .gnt     (gnt),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    // Issue-side reassembly from the granted half
    always_comb begin
        g_ent    = gnt_idx[SLOT_W-1:1];
        g_rt     = gnt_idx[0];
        iss_vld  = gnt_vld;
        iss_slot = gnt_idx;
        iss_op   = '0;
        iss_dst  = '0;
        iss_s0   = '0;
        iss_s1   = '0;
        if (gnt_vld) begin
            iss_op  = g_rt ? op_r_a[g_ent]  : op_l_a[g_ent];
            iss_dst = g_rt ? dst_r_a[g_ent] : dst_l_a[g_ent];
            iss_s0  = g_rt ? s0_r_a[g_ent]  : s0_l_a[g_ent];
            iss_s1  = g_rt ? s1_r_a[g_ent]  : s1_l_a[g_ent];
        end
    end

    AST_ISSUE_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |-> req_all[iss_slot]);                                       // R9

endmodule

// File: tb/sim_pkiq_top.sv
`timescale 1ns/1ps
module sim_pkiq_top;

    localparam int NE = 8;
    localparam int TW = 6;
    localparam int OW = 4;
    localparam int NB = 2;
    localparam int SW = $clog2(2*NE);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            dsp_vld = 1'b0;
    logic [OW-1:0]   dsp_op = '0;
    logic [TW-1:0]   dsp_dst = '0, dsp_s0 = '0, dsp_s1 = '0;
    logic            dsp_s0_rdy = 1'b0, dsp_s1_rdy = 1'b0;
    logic            dsp_acc;
    logic [NB-1:0]   wk_vld = '0;
    logic [NB*TW-1:0] wk_tag = '0;
    logic [NE-1:0]   req_lo, req_hi;
    logic            iss_vld;
    logic [SW-1:0]   iss_slot;
    logic [OW-1:0]   iss_op;
    logic [TW-1:0]   iss_dst, iss_s0, iss_s1;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    pkiq_top #(.NUM_ENT(NE), .TAG_W(TW), .OP_W(OW), .NUM_BUS(NB)) u0 (
        .clk(clk), .rst_n(rst_n),
        .dsp_vld(dsp_vld), .dsp_op(dsp_op), .dsp_dst(dsp_dst),
        .dsp_s0(dsp_s0), .dsp_s0_rdy(dsp_s0_rdy),
        .dsp_s1(dsp_s1), .dsp_s1_rdy(dsp_s1_rdy), .dsp_acc(dsp_acc),
        .wk_vld(wk_vld), .wk_tag(wk_tag),
        .req_lo(req_lo), .req_hi(req_hi),
        .iss_vld(iss_vld), .iss_slot(iss_slot), .iss_op(iss_op),
        .iss_dst(iss_dst), .iss_s0(iss_s0), .iss_s1(iss_s1)
    );

    // Model: 0 empty, 1 left, 2 right, 3 both, 4 full (full data in half 1)
    int            mst [NE];
    logic [TW-1:0] mct [NE][2];
    bit            mv  [NE][2];
    logic [OW-1:0] mop [NE][2];
    logic [TW-1:0] mdst[NE][2];
    logic [TW-1:0] ms0 [NE][2];
    logic [TW-1:0] ms1 [NE][2];

    bit p_gv, p_acc, p_full;
    int p_gs, p_e, p_h;

    task automatic chk(input string r, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h", r, act, exp);
        end
    endtask

    function automatic bit mhit(input logic [TW-1:0] t);
        for (int b = 0; b < NB; b++)
            if (wk_vld[b] && wk_tag[b*TW +: TW] == t) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_reset();
        for (int e = 0; e < NE; e++) begin
            mst[e] = 0;
            mv[e][0] = 0; mv[e][1] = 0;
        end
    endtask

    task automatic predict_and_check();
        logic [NE-1:0] el, eh;
        int pe, ee;
        bit ok;
        for (int e = 0; e < NE; e++) begin
            el[e] = (mst[e] == 1 || mst[e] == 3) && mv[e][0];
            eh[e] = ((mst[e] == 2 || mst[e] == 3) && mv[e][1]) ||
                    (mst[e] == 4 && mv[e][0] && mv[e][1]);
        end
        p_gv = 0; p_gs = 0;
        for (int s = 0; s < 2*NE; s++)
            if (!p_gv && ((s % 2) ? eh[s/2] : el[s/2])) begin
                p_gv = 1; p_gs = s;
            end
        pe = -1; ee = -1;
        for (int e = 0; e < NE; e++) begin
            if (pe < 0 && (mst[e] == 1 || mst[e] == 2)) pe = e;
            if (ee < 0 && mst[e] == 0) ee = e;
        end
        p_full = !dsp_s0_rdy && !dsp_s1_rdy;
        if (p_full) begin
            ok = (ee >= 0); p_e = ee; p_h = 1;
        end else if (pe >= 0) begin
            ok = 1; p_e = pe; p_h = (mst[pe] == 1) ? 1 : 0;
        end else begin
            ok = (ee >= 0); p_e = ee; p_h = 0;
        end
        p_acc = dsp_vld && ok;
        chk(p_full ? "R4 dsp_acc" : "R3 dsp_acc", int'(dsp_acc), int'(p_acc));
        chk("R6 req_lo", int'(req_lo), int'(el));
        chk("R7 req_hi", int'(req_hi), int'(eh));
        chk("R9 iss_vld", int'(iss_vld), int'(p_gv));
        if (p_gv) begin
            chk("R9 iss_slot", int'(iss_slot), p_gs);
            chk("R10 iss_op",  int'(iss_op),  int'(mop[p_gs/2][p_gs%2]));
            chk("R10 iss_dst", int'(iss_dst), int'(mdst[p_gs/2][p_gs%2]));
            chk("R10 iss_s0",  int'(iss_s0),  int'(ms0[p_gs/2][p_gs%2]));
            chk("R10 iss_s1",  int'(iss_s1),  int'(ms1[p_gs/2][p_gs%2]));
        end
    endtask

    task automatic model_update();
        logic [TW-1:0] cam;
        bit crdy;
        int e, h;
        for (int i = 0; i < NE; i++)
            for (int j = 0; j < 2; j++)
                if (mhit(mct[i][j])) mv[i][j] = 1;
        if (p_gv) begin
            e = p_gs / 2; h = p_gs % 2;
            if (mst[e] == 3) mst[e] = h ? 1 : 2;
            else             mst[e] = 0;
        end
        if (p_acc) begin
            e = p_e; h = p_h;
            mop[e][h] = dsp_op; mdst[e][h] = dsp_dst;
            ms0[e][h] = dsp_s0; ms1[e][h] = dsp_s1;
            if (p_full) begin
                mst[e] = 4;
                mct[e][1] = dsp_s0; mct[e][0] = dsp_s1;
                mv[e][1] = mhit(dsp_s0); mv[e][0] = mhit(dsp_s1);
            end else begin
                if (!dsp_s0_rdy)      begin cam = dsp_s0; crdy = 0; end
                else if (!dsp_s1_rdy) begin cam = dsp_s1; crdy = 0; end
                else                  begin cam = dsp_s0; crdy = 1; end
                mst[e] = (mst[e] == 0) ? (h ? 2 : 1) : 3;
                mct[e][h] = cam;
                mv[e][h] = crdy | mhit(cam);
            end
        end
    endtask

    // Called 1 ns after inputs change at the falling edge
    task automatic tick();
        predict_and_check();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle_in();
        dsp_vld = 0; wk_vld = '0;
    endtask

    task automatic disp(input int op, input int dst, input int s0, input bit r0,
                        input int s1, input bit r1);
        dsp_vld = 1; dsp_op = OW'(op); dsp_dst = TW'(dst);
        dsp_s0 = TW'(s0); dsp_s0_rdy = r0; dsp_s1 = TW'(s1); dsp_s1_rdy = r1;
    endtask

    task automatic wake(input int b, input int t);
        wk_vld[b] = 1'b1; wk_tag[b*TW +: TW] = TW'(t);
    endtask

    task automatic rnd(input int pd, input int pw);
        dsp_vld = ($urandom % 100) < pd;
        dsp_op = OW'($urandom); dsp_dst = TW'($urandom);
        dsp_s0 = TW'($urandom % 12); dsp_s1 = TW'($urandom % 12);
        dsp_s0_rdy = $urandom % 2; dsp_s1_rdy = $urandom % 2;
        for (int b = 0; b < NB; b++) begin
            wk_vld[b] = ($urandom % 100) < pw;
            wk_tag[b*TW +: TW] = TW'($urandom % 12);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog R9 act=running exp=finished");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        process::self().srandom(7);
        model_reset();
        @(negedge clk);
        dsp_vld = 1; dsp_s0_rdy = 1; dsp_s1_rdy = 1;
        repeat (2) @(negedge clk);
        #1;
        // R1: reset state
        chk("R1 req_lo", int'(req_lo), 0);
        chk("R1 req_hi", int'(req_hi), 0);
        chk("R1 iss_vld", int'(iss_vld), 0);
        chk("R1 dsp_acc", int'(dsp_acc), 1);
        @(negedge clk);
        rst_n = 1;
        idle_in();
        #1; tick();

        // Full instruction into entry 0
        disp(1, 10, 20, 0, 21, 0);
        #1; tick();
        // R2: full entry waits; half ready goes to entry 1 left
        idle_in(); disp(2, 11, 22, 1, 23, 1);
        #1;
        chk("R2 req_lo[0]", int'(req_lo[0]), 0);
        chk("R2 req_hi[0]", int'(req_hi[0]), 0);
        tick();
        // R5: ready half requests the cycle after dispatch
        idle_in(); wake(0, 20);
        #1;
        chk("R5 req_lo[1]", int'(req_lo[1]), 1);
        chk("R5 iss_slot", int'(iss_slot), 2);
        tick();
        // R11: granted half released; R7: one source alone does not ready a full entry
        idle_in(); wake(1, 21);
        #1;
        chk("R11 req_lo[1]", int'(req_lo[1]), 0);
        chk("R7 req_hi[0]", int'(req_hi[0]), 0);
        tick();
        idle_in();
        #1;
        chk("R7 req_hi[0]", int'(req_hi[0]), 1);
        chk("R7 req_lo[0]", int'(req_lo[0]), 0);
        chk("R7 iss_slot", int'(iss_slot), 1);
        tick();
        // R12: entry 0 is empty again and takes a full instruction
        idle_in(); disp(3, 12, 30, 0, 31, 0);
        #1;
        chk("R11 req_hi[0]", int'(req_hi[0]), 0);
        chk("R12 dsp_acc", int'(dsp_acc), 1);
        tick();
        // R8: wakeup in the dispatch cycle is not lost
        idle_in(); disp(4, 13, 40, 0, 41, 1); wake(0, 40);
        #1; tick();
        idle_in();
        #1;
        chk("R8 req_lo[1]", int'(req_lo[1]), 1);
        tick();
        for (int i = 0; i < 6; i++) begin
            wake(0, 30); wake(1, 31);
            #1; tick();
            idle_in();
        end

        // Sweeps: fill-heavy, wake-heavy, balanced
        for (int i = 0; i < 1500; i++) begin rnd(90, 15); #1; tick(); end
        for (int i = 0; i < 1500; i++) begin rnd(30, 80); #1; tick(); end
        for (int i = 0; i < 1500; i++) begin rnd(60, 45); #1; tick(); end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule